// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block sits next to the program counter of a small microcontroller and decides when execution must jump to a fixed vector address. It has three causes for a jump. The first is reset. The second is a falling edge on an external interrupt pin. The third is an overflow pulse from one of up to two timer/event counters. Each interrupt cause has its own enable bit. There is also a software master enable and an internal interrupt-enable flag.

When the block takes a jump, it raises a vector load request that carries the target address. When the jump is an interrupt, it also raises a one-cycle push request, so that the return address is saved on the hardware call stack. No interrupt is serviced while the call stack reports full. In that case the request waits in its pending latch until the stack has room.

Every request source keeps a pending flag until it is served. The pending flags are visible on an output. A return-from-interrupt strobe re-opens the internal enable after a service routine ends.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While `rst_ni` is low, and for the first clock cycle after it rises, `vec_load_o` is 1, `vec_addr_o` is 0x000 and `push_o` is 0.
- R2: `ext_irq_i` passes through two synchronising flops. Each high-to-low transition on it sets `pend_o[0]`, and the flag is visible two clocks after the edge that first samples the low level. A low-to-high transition sets nothing.
- R3: The vector addresses are 0x004 for the external pin (`pend_o[0]`), 0x008 for timer 0 (`pend_o[1]`, `tmr_ovf_i[0]`) and 0x00C for timer 1 (`pend_o[2]`, `tmr_ovf_i[1]`). All other `vec_addr_o` bits are zero.
- R4: A pending source is taken only while its own enable bit is 1 and `glb_en_i` is 1. While it is masked, its pending flag stays set.
- R5: No interrupt is taken in a cycle where `stk_full_i` is 1. The pending flags are kept.
- R6: A pending flag stays set until its source is served.
- R7: When several enabled sources are pending, the external pin is served first, then timer 0, then timer 1.
- R8: A service sets `vec_load_o` and `push_o` together for exactly one cycle. This happens one clock after the edge where the source was eligible. `gie_o` drops to 0 in that same cycle.
- R9: While `gie_o` is 0, nothing is taken. A one-cycle `reti_i` pulse sets `gie_o` back to 1 from the next cycle on.
- R10: A second overflow pulse that arrives while its source is already pending is merged into that source's single pending request. It produces only one service.
- R11: With `NUM_TIMERS` set to 1, the address 0x00C is never issued.
- R12: A service clears the pending flag of the source it served. Other pending flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 1 | External interrupt pin, asynchronous, falling-edge active |
| tmr_ovf_i | input | NUM_TIMERS | One-cycle overflow pulses from the timers |
| ext_en_i | input | 1 | Enable for the external interrupt |
| tmr_en_i | input | NUM_TIMERS | Enables for the timer interrupts |
| glb_en_i | input | 1 | Software master interrupt enable |
| stk_full_i | input | 1 | Call stack full |
| reti_i | input | 1 | Return-from-interrupt strobe |
| vec_load_o | output | 1 | Load `vec_addr_o` into the program counter |
| vec_addr_o | output | ADDR_W | Target vector address |
| push_o | output | 1 | Push the return address |
| gie_o | output | 1 | Internal interrupt enable flag |
| pend_o | output | NUM_TIMERS+1 | Pending flags, external in bit 0 |

## Verification
The bench runs a behavioural reference model alongside the design and compares all outputs on every cycle. It also makes directed checks on the following patterns:
- Single falling and rising edges on the pin separate edge sensing from level sensing.
- Firing all three sources at once while the stack is full checks that requests are held under the stack block, and then that they are released in priority order.
- Masked sources, a cleared master enable and a service routine that has not yet returned show that each gate holds requests back without losing them.
- Two timer pulses inside one blocked window separate merging from counting.
- A second instance with a single timer confirms that the third vector never appears.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int unsigned SRC_EXT = 0;

  function automatic int unsigned vec_of_src(input int unsigned idx, input int unsigned stride);
    return (idx + 1) * stride;
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], pin_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= pin_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];

  AST_FALL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R2
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      // new event wins over a same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       pend_q[i] <= 1'b0;
        else if (set_i[i]) pend_q[i] <= 1'b1;
        else if (clr_i[i]) pend_q[i] <= 1'b0;
      end

      AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_q[i] && !clr_i[i] |=> pend_q[i]); // R6
      AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i[i] && !set_i[i] |=> !pend_q[i]); // R12
      AST_PEND_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pend_q[i] && !set_i[i] |=> !pend_q[i]); // R2
    end
  endgenerate

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned NSRC   = 3,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned STRIDE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   req_i,
  output logic [NSRC-1:0]   gnt_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  import vec_irq_pkg::*;

  always_comb begin
    gnt_o  = '0;
    addr_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o     = '0;
        gnt_o[i]  = 1'b1;
        addr_o    = ADDR_W'(vec_of_src(i, STRIDE));
      end
    end
  end

  assign valid_o = |req_i;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R7
  AST_GNT_IN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0); // R4

  generate
    for (genvar i = 1; i < NSRC; i++) begin : g_prio_chk
      AST_GNT_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt_o[i] |-> req_i[i-1:0] == '0); // R7
    end
  endgenerate
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned NUM_TIMERS  = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VEC_STRIDE  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ext_irq_i,
  input  logic [NUM_TIMERS-1:0] tmr_ovf_i,
  input  logic                  ext_en_i,
  input  logic [NUM_TIMERS-1:0] tmr_en_i,
  input  logic                  glb_en_i,
  input  logic                  stk_full_i,
  input  logic                  reti_i,
  output logic                  vec_load_o,
  output logic [ADDR_W-1:0]     vec_addr_o,
  output logic                  push_o,
  output logic                  gie_o,
  output logic [NUM_TIMERS:0]   pend_o
);
  localparam int unsigned NSRC = NUM_TIMERS + 1;

  logic              ext_fall;
  logic [NSRC-1:0]   src_set, src_en, pend, req, gnt, clr;
  logic              sel_valid, take;
  logic [ADDR_W-1:0] sel_addr;
  logic              rst_req_q, load_q, push_q, gie_q;
  logic [ADDR_W-1:0] addr_q;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .pin_i(ext_irq_i), .fall_o(ext_fall)
  );

  assign src_set = {tmr_ovf_i, ext_fall};
  assign src_en  = {tmr_en_i, ext_en_i};

  irq_pend #(.NSRC(NSRC)) i_pend (
    .clk_i, .rst_ni, .set_i(src_set), .clr_i(clr), .pend_o(pend)
  );

  assign req = pend & src_en;

  irq_prio_sel #(.NSRC(NSRC), .ADDR_W(ADDR_W), .STRIDE(VEC_STRIDE)) i_sel (
    .clk_i, .rst_ni, .req_i(req), .gnt_o(gnt), .valid_o(sel_valid), .addr_o(sel_addr)
  );

  assign take = sel_valid & gie_q & glb_en_i & ~stk_full_i & ~rst_req_q;
  assign clr  = take ? gnt : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_q <= 1'b1;
      load_q    <= 1'b1;
      push_q    <= 1'b0;
      addr_q    <= '0;
      gie_q     <= 1'b1;
    end else begin
      rst_req_q <= 1'b0;
      load_q    <= rst_req_q | take;
      push_q    <= take;
      addr_q    <= take ? sel_addr : '0;
      if (take)        gie_q <= 1'b0;
      else if (reti_i) gie_q <= 1'b1;
    end
  end

  assign vec_load_o = load_q;
  assign vec_addr_o = addr_q;
  assign push_o     = push_q;
  assign gie_o      = gie_q;
  assign pend_o     = pend;

  AST_RESET_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_load_o && !push_o |-> vec_addr_o == '0); // R1
  AST_VEC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (vec_addr_o != '0) && ((vec_addr_o % VEC_STRIDE) == 0)
               && (vec_addr_o <= ADDR_W'(NSRC * VEC_STRIDE))); // R3
  AST_GLB_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(glb_en_i)); // R4
  AST_STACK_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !$past(stk_full_i)); // R5
  AST_PUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o); // R8
  AST_PUSH_WITH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> vec_load_o && !gie_o); // R8
  AST_RETI_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i && !take |=> gie_o); // R9
  AST_GIE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_o |=> !push_o); // R9

  generate
    if (NUM_TIMERS == 1) begin : g_one_timer
      AST_NO_THIRD_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_load_o |-> vec_addr_o != ADDR_W'(3 * VEC_STRIDE)); // R11
    end
  endgenerate
endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1;
  logic [1:0] ovf = '0;
  logic ext_en = 1'b1;
  logic [1:0] tmr_en = 2'b11;
  logic glb_en = 1'b1, stk = 1'b0, reti = 1'b0;
  logic load, push, gie;
  logic [12:0] addr;
  logic [2:0] pend;
  logic load1, push1, gie1;
  logic [12:0] addr1;
  logic [1:0] pend1;

  int n_chk = 0, n_fail = 0, cyc = 0, t0_hits = 0;
  bit started = 0;

  always #2 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_irq_i(pin), .tmr_ovf_i(ovf),
    .ext_en_i(ext_en), .tmr_en_i(tmr_en), .glb_en_i(glb_en), .stk_full_i(stk),
    .reti_i(reti), .vec_load_o(load), .vec_addr_o(addr), .push_o(push),
    .gie_o(gie), .pend_o(pend)
  );

  vec_irq_ctrl #(.NUM_TIMERS(1)) i_vec_irq_ctrl_one (
    .clk_i(clk), .rst_ni(rst_n), .ext_irq_i(pin), .tmr_ovf_i(ovf[0]),
    .ext_en_i(ext_en), .tmr_en_i(tmr_en[0]), .glb_en_i(glb_en), .stk_full_i(stk),
    .reti_i(reti), .vec_load_o(load1), .vec_addr_o(addr1), .push_o(push1),
    .gie_o(gie1), .pend_o(pend1)
  );

  // behavioural reference
  int m_pipe[$];
  int m_pend, m_addr;
  bit m_gie, m_rr, m_load, m_push;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pipe = '{1, 1, 1};
      m_pend = 0; m_gie = 1; m_rr = 1; m_load = 1; m_push = 0; m_addr = 0;
    end else begin
      int fall, sel, setv;
      fall = (m_pipe[2] == 1 && m_pipe[1] == 0) ? 1 : 0;
      sel = -1;
      for (int i = 2; i >= 0; i--) begin
        bit en_b;
        en_b = (i == 0) ? ext_en : tmr_en[i-1];
        if (((m_pend >> i) & 1) == 1 && en_b) sel = i;
      end
      if (m_rr) begin
        m_load = 1; m_addr = 0; m_push = 0;
      end else if (sel >= 0 && m_gie && glb_en && !stk) begin
        m_load = 1; m_addr = (sel + 1) * 4; m_push = 1;
        m_pend = m_pend & ~(1 << sel);
        m_gie = 0;
      end else begin
        m_load = 0; m_addr = 0; m_push = 0;
        if (reti) m_gie = 1;
      end
      setv = fall | (int'(ovf) << 1);
      m_pend = m_pend | setv;
      m_pipe.push_front(int'(pin));
      void'(m_pipe.pop_back());
      m_rr = 0;
    end
  end

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (started) begin
      chk(int'(load), int'(m_load), "R1 load");
      chk(int'(addr), m_addr, "R3 addr");
      chk(int'(push), int'(m_push), "R8 push");
      chk(int'(gie), int'(m_gie), "R9 gie");
      chk(int'(pend), m_pend, "R6 pend");
      if (load1) chk((addr1 == 13'h00C) ? 1 : 0, 0, "R11 no third vector");
      if (push1 && addr1 == 13'h008) t0_hits++;
    end
    if (cyc > 20000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_push(output int a, input int lim);
    a = -1;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (push) begin a = int'(addr); return; end
    end
  endtask

  task automatic pulse_reti();
    reti = 1; step(1); reti = 0;
  endtask

  task automatic pulse_ovf(input int idx);
    ovf[idx] = 1'b1; step(1); ovf[idx] = 1'b0;
  endtask

  task automatic no_push(input int n, input string req);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (push) seen++;
    end
    chk(seen, 0, req);
  endtask

  initial begin
    int a;
    step(3);
    chk(int'(load), 1, "R1 load in reset");
    chk(int'(push), 0, "R1 push in reset");
    rst_n = 1'b1;
    started = 1;
    step(1);
    chk(int'(load), 1, "R1 load after reset");
    chk(int'(addr), 0, "R1 addr after reset");
    step(1);
    chk(int'(load), 0, "R1 load drops");

    // R2 falling edge -> 0x004
    pin = 1'b0;
    wait_push(a, 10); chk(a, 4, "R2 R3 ext vector");
    chk(int'(pend[0]), 0, "R12 ext cleared");
    pulse_reti();
    pin = 1'b1;
    no_push(8, "R2 rising edge ignored");
    chk(int'(pend), 0, "R2 no pending on rise");

    pulse_ovf(0);
    wait_push(a, 10); chk(a, 8, "R3 timer0 vector");
    pulse_reti();
    pulse_ovf(1);
    wait_push(a, 10); chk(a, 12, "R3 timer1 vector");
    pulse_reti();

    // R5 / R7 all pending under stack full
    stk = 1'b1;
    pin = 1'b0;
    ovf = 2'b11; step(1); ovf = 2'b00;
    no_push(8, "R5 stack full blocks");
    chk(int'(pend), 7, "R5 pending kept");
    stk = 1'b0;
    wait_push(a, 10); chk(a, 4, "R7 ext first");
    chk(int'(pend), 6, "R12 others kept");
    pulse_reti();
    wait_push(a, 10); chk(a, 8, "R7 timer0 second");
    pulse_reti();
    wait_push(a, 10); chk(a, 12, "R7 timer1 third");
    pulse_reti();
    pin = 1'b1;
    step(4);

    // R4 per-source and global enable
    tmr_en[0] = 1'b0;
    pulse_ovf(0);
    no_push(6, "R4 masked source");
    chk(int'(pend[1]), 1, "R4 masked stays pending");
    tmr_en[0] = 1'b1;
    wait_push(a, 10); chk(a, 8, "R4 unmasked taken");
    pulse_reti();
    glb_en = 1'b0;
    pulse_ovf(1);
    no_push(6, "R4 global disable");
    glb_en = 1'b1;
    wait_push(a, 10); chk(a, 12, "R4 global enable");
    pulse_reti();

    // R10 merge
    stk = 1'b1;
    pulse_ovf(1); step(2); pulse_ovf(1);
    step(2);
    stk = 1'b0;
    wait_push(a, 10); chk(a, 12, "R10 merged service");
    pulse_reti();
    no_push(10, "R10 no second service");

    // R9 gie blocks until reti
    pulse_ovf(0);
    wait_push(a, 10); chk(a, 8, "R9 first take");
    pulse_ovf(1);
    no_push(8, "R9 blocked while gie low");
    chk(int'(gie), 0, "R9 gie low");
    pulse_reti();
    chk(int'(gie), 1, "R9 gie restored");
    wait_push(a, 10); chk(a, 12, "R9 taken after reti");
    pulse_reti();
    step(4);

    chk((t0_hits > 0) ? 1 : 0, 1, "R11 single-timer uses 0x008");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule